// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Comparator

This block is the comparison stage of a digital phase-locked loop. It watches a reference signal and a feedback signal, the latter coming back from the loop oscillator, often through a divider. A fast system clock samples both single-bit inputs through synchronizers. Only their rising edges count, so their duty cycles do not matter.

The loop output has three conditions, carried on two enables. Pump-up asks the loop to speed up. Pump-down asks it to slow down. With both enables low the output floats, and the downstream filter holds its value. The block drives the float condition as its own output, and it also drives a lock pulse that is high only while the output floats. While the two inputs agree in frequency and phase, the lock pulse stays high.

A rising reference edge moves the comparator one step toward pump-up. A rising feedback edge moves it one step toward pump-down. Each pulse therefore lasts as long as the time between the two edges. With unequal frequencies, the faster input keeps its own pump active for most of the time.

Top module: `phase_freq_det`

## Requirements
- R1: While reset is asserted, and after it is released with no input edge, up_en=0, dn_en=0, out_z=1 and lock_pulse=1. Asserting rst_n low forces this state at once, whatever state the block was in.
- R2: A rising edge on ref_in while floating sets up_en. A rising edge on fb_in clears it again. With fb_in rising D clock cycles after ref_in, up_en is high for exactly D cycles.
- R3: A rising edge on fb_in while floating sets dn_en. A rising edge on ref_in clears it again. With ref_in rising D cycles after fb_in, dn_en is high for exactly D cycles.
- R4: An input change that meets the clock is seen at the outputs after the third rising clock edge: two synchronizer stages, then the output register.
- R5: Rising edges of both inputs that are detected in the same clock cycle cancel: up_en and dn_en keep their values.
- R6: Falling edges and input duty cycle have no effect. With the same input periods, the count of up and down cycles is the same for a 20% and an 80% reference duty cycle.
- R7: up_en and dn_en are never high together, and the block never goes from pump-up straight to pump-down or back. out_z equals NOT(up_en OR dn_en), and lock_pulse equals out_z in every cycle.
- R8: With the reference faster than the feedback, and starting from float, up_en is active in some cycles and dn_en in none. With the reference slower, the roles swap.
- R9: Inputs equal in frequency and phase leave the output floating and lock_pulse high for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal from the oscillator path, asynchronous |
| up_en | output | 1 | Pump-up drive enable |
| dn_en | output | 1 | Pump-down drive enable |
| out_z | output | 1 | High when neither drive is enabled (output floating) |
| lock_pulse | output | 1 | High while the output floats; marks lock |

## Verification
The hardest condition to reach is the cancel case inside a pump state. The block must already be pumping up, and then rising edges on both inputs must land in the same sampling cycle. The bench drives one edge alone to enter the pump state. It then lowers both inputs, which also shows that falling edges do nothing. Finally it raises both inputs on the same falling clock edge, so that the matched synchronizers present both edges together, and checks that up_en holds. Frequency-offset runs start from a shared rising edge, which cancels, so that the counts of up and down cycles are exact and can be compared across duty cycles.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    ST_FLOAT = 2'b00,
    ST_UP    = 2'b01,
    ST_DN    = 2'b10
  } pump_state_t;
endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg_q[STAGES-1];
endmodule

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up_en,
  output logic dn_en,
  output logic out_z,
  output logic lock_pulse
);
  pump_state_t state_q, state_nxt;
  logic        upd_en;

  // a lone edge advances the state; coincident edges cancel
  assign upd_en = ref_rise ^ fb_rise;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_FLOAT: state_nxt = ref_rise ? ST_UP : ST_DN;
      ST_UP:    if (fb_rise)  state_nxt = ST_FLOAT;
      ST_DN:    if (ref_rise) state_nxt = ST_FLOAT;
      default:  state_nxt = ST_FLOAT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_FLOAT;
      up_en      <= 1'b0;
      dn_en      <= 1'b0;
      out_z      <= 1'b1;
      lock_pulse <= 1'b1;
    end else if (upd_en) begin
      state_q    <= state_nxt;
      up_en      <= (state_nxt == ST_UP);
      dn_en      <= (state_nxt == ST_DN);
      out_z      <= (state_nxt == ST_FLOAT);
      lock_pulse <= (state_nxt == ST_FLOAT);
    end
  end
endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_en,
  output logic dn_en,
  output logic out_z,
  output logic lock_pulse
);
  logic rst_sync_n;
  logic ref_rise;
  logic fb_rise;

  pfd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (ref_in),
    .rise  (ref_rise)
  );

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (fb_in),
    .rise  (fb_rise)
  );

  pfd_core u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ref_rise   (ref_rise),
    .fb_rise    (fb_rise),
    .up_en      (up_en),
    .dn_en      (dn_en),
    .out_z      (out_z),
    .lock_pulse (lock_pulse)
  );
endmodule

// File: rtl/pfd_chk.sv
module pfd_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_rise,
  input logic fb_rise,
  input logic up_en,
  input logic dn_en,
  input logic out_z,
  input logic lock_pulse
);
  // R7
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_en && dn_en));

  // R7
  float_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_z == !(up_en || dn_en));

  // R7
  lock_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse == out_z);

  // R7
  no_up_to_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> !dn_en);

  // R2
  up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_en) |-> ($past(ref_rise) && !$past(fb_rise)));

  // R3
  dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_en) |-> ($past(fb_rise) && !$past(ref_rise)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise == fb_rise) |=> ($stable(up_en) && $stable(dn_en)));
endmodule

bind phase_freq_det pfd_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ref_rise   (ref_rise),
  .fb_rise    (fb_rise),
  .up_en      (up_en),
  .dn_en      (dn_en),
  .out_z      (out_z),
  .lock_pulse (lock_pulse)
);

// File: tb/test_phase_freq_det.sv
module test_phase_freq_det;
  logic clk = 1'b0;
  logic rst_n;
  logic ref_in, fb_in;
  logic up_en, dn_en, out_z, lock_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  phase_freq_det i_phase_freq_det (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .up_en(up_en), .dn_en(dn_en), .out_z(out_z), .lock_pulse(lock_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_float(input string req, input string what);
    chk(!up_en && !dn_en && out_z && lock_pulse, req, what,
        {up_en, dn_en, out_z, lock_pulse}, 4'b0011);
  endtask

  // bring the block back to float through its inputs
  task automatic settle();
    ref_in = 0; fb_in = 0;
    repeat (6) @(negedge clk);
    if (up_en) begin
      fb_in = 1; repeat (6) @(negedge clk); fb_in = 0; repeat (6) @(negedge clk);
    end else if (dn_en) begin
      ref_in = 1; repeat (6) @(negedge clk); ref_in = 0; repeat (6) @(negedge clk);
    end
    chk_float("R1", "settle to float");
  endtask

  task automatic t_reset();
    ref_in = 0; fb_in = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk_float("R1", "during reset");
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk_float("R1", "after release");
  endtask

  // lead_ref=1: ref leads fb by d; else fb leads ref by d
  task automatic t_phase(input bit lead_ref, input int d);
    int up_c = 0, dn_c = 0, first = -1, bad = 0;
    for (int i = 0; i < d + 10; i++) begin
      @(negedge clk);
      if (up_en) up_c++;
      if (dn_en) dn_c++;
      if ((up_en || dn_en) && first < 0) first = i;
      if (lock_pulse != !(up_en || dn_en) || out_z != lock_pulse) bad++;
      if (i == 0) begin if (lead_ref) ref_in = 1; else fb_in = 1; end
      if (i == d) begin if (lead_ref) fb_in = 1; else ref_in = 1; end
    end
    if (lead_ref) begin
      chk(up_c == d, "R2", "up width", up_c, d);
      chk(dn_c == 0, "R2", "dn during ref lead", dn_c, 0);
    end else begin
      chk(dn_c == d, "R3", "dn width", dn_c, d);
      chk(up_c == 0, "R3", "up during fb lead", up_c, 0);
    end
    chk(first == 3, "R4", "latency to first pump cycle", first, 3);
    chk(bad == 0, "R7", "lock/out_z mismatch", bad, 0);
    settle();
  endtask

  task automatic t_cancel();
    // from float: coincident edges
    @(negedge clk); ref_in = 1; fb_in = 1;
    repeat (8) @(negedge clk);
    chk_float("R5", "coincident edges from float");
    ref_in = 0; fb_in = 0; repeat (4) @(negedge clk);
    // enter pump-up, then a falling edge, then coincident edges
    ref_in = 1; repeat (6) @(negedge clk);
    chk(up_en == 1, "R2", "up after ref edge", up_en, 1);
    ref_in = 0; repeat (6) @(negedge clk);
    chk(up_en == 1 && !dn_en, "R6", "falling ref ignored", up_en, 1);
    ref_in = 1; fb_in = 1; repeat (8) @(negedge clk);
    chk(up_en == 1 && !dn_en, "R5", "coincident edges in up", up_en, 1);
    fb_in = 0; repeat (4) @(negedge clk);
    fb_in = 1; repeat (6) @(negedge clk);
    chk_float("R2", "fb edge ends up");
    settle();
  endtask

  task automatic run_wave(input int pr, input int pf, input int duty_r,
                          input int n, output int up_c, output int dn_c,
                          output int bad);
    up_c = 0; dn_c = 0; bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (up_en) up_c++;
      if (dn_en) dn_c++;
      if ((up_en && dn_en) || lock_pulse != out_z) bad++;
      ref_in = (i % pr) < (pr * duty_r / 100);
      fb_in  = (i % pf) < (pf / 2);
    end
  endtask

  task automatic t_freq();
    int u1, d1, b1, u2, d2, b2;
    run_wave(10, 14, 50, 300, u1, d1, b1);
    chk(u1 > 0 && d1 == 0, "R8", "ref faster: up only", d1, 0);
    chk(b1 == 0, "R7", "exclusive outputs", b1, 0);
    settle();
    run_wave(14, 10, 50, 300, u1, d1, b1);
    chk(d1 > 0 && u1 == 0, "R8", "ref slower: dn only", u1, 0);
    settle();
    run_wave(10, 14, 20, 300, u1, d1, b1);
    settle();
    run_wave(10, 14, 80, 300, u2, d2, b2);
    chk(u1 == u2 && d1 == d2, "R6", "duty independence up", u2, u1);
    chk(b1 == 0 && b2 == 0, "R7", "exclusive outputs duty", b1 + b2, 0);
    settle();
    run_wave(12, 12, 50, 240, u1, d1, b1);
    chk(u1 == 0 && d1 == 0, "R9", "equal phase and freq pump cycles", u1 + d1, 0);
    settle();
  endtask

  task automatic t_async_reset();
    ref_in = 1; repeat (6) @(negedge clk);
    chk(up_en == 1, "R2", "up before reset", up_en, 1);
    #2 rst_n = 0; #1;
    chk_float("R1", "immediate on reset assert");
    ref_in = 0; @(negedge clk); rst_n = 1;
    repeat (6) @(negedge clk);
    chk_float("R1", "after second release");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ref_in = 0; fb_in = 0;
    t_reset();
    t_phase(1, 1);
    t_phase(1, 7);
    t_phase(0, 4);
    t_phase(0, 12);
    t_cancel();
    t_freq();
    t_async_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule